// File: doc/BRIEF.md
# Four-Bit NAND / Add / Subtract ALU

This block is a purely combinational arithmetic and logic unit for two 4-bit operands. A 2-bit operation code selects one of three functions: bitwise NAND, addition, or two's-complement subtraction. It returns a 4-bit result, a carry flag and a zero flag. The adder is an explicit chain of one-bit full-adder stages. Each stage builds its sum from XOR and its carry from AND terms, and the carry ripples from bit 0 up to the top bit.

Subtraction runs on the same chain. The upper opcode bit inverts B through XOR gates. When both opcode bits are set, a carry of one also enters the lowest stage, so the chain forms A + ~B + 1. The carry flag is always the raw carry out of the last stage. After a subtraction it therefore reads 1 when no borrow occurred. The zero flag is high whenever the selected result is all zeros. No signed-overflow flag exists.

The unused code 10 is defined as well: it gives A + ~B with no carry-in, which equals A − B − 1. Under NAND the carry flag reports the carry of A + B, so it never floats.

Top module: `nas_alu`

## Requirements
- R1: Opcode 00 gives result = bitwise NOT(A AND B).
- R2: Opcode 01 gives result = (A + B) mod 16, and carry = 1 exactly when A + B ≥ 16.
- R3: Opcode 11 gives result = (A − B) mod 16, and carry = 1 exactly when A ≥ B (raw carry, no borrow inversion). For example, 0111 − 0010 = 0101 with carry 1.
- R4: Opcode 10 gives result = (A + NOT B) mod 16, that is A − B − 1, and carry = 1 exactly when A > B.
- R5: Under opcode 00 the carry flag equals the carry of A + B, so it is never undefined.
- R6: The zero flag is 1 exactly when the 4-bit result of the selected operation is 0000, for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| op_i | input | 2 | Operation code: bit 1 inverts B, bits 1 and 0 together add carry-in |
| result_o | output | 4 | Selected result |
| carry_o | output | 1 | Carry out of the most significant adder stage |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
Immediate assertions re-check every evaluation inside the RTL:
- each full-adder stage against its two-bit arithmetic sum,
- the whole ripple chain against a word-wide addition,
- the zero tree against a plain comparison,
- each opcode's result and carry against an inverse arithmetic identity, such as result + B = A for subtraction.

The assertions cannot show that every opcode is actually reached, or that the flags take their intended values on the specific corner points: 0 − 0, 15 + 1, A = B, and 1111 NAND 1111. The bench shows these by sweeping all 1024 operand and opcode combinations through a scoreboard, plus directed corner cases.

// File: rtl/nas_alu_pkg.sv
package nas_alu_pkg;

   localparam int OP_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_NAND   = 2'b00,
      OP_ADD    = 2'b01,
      OP_ADDINV = 2'b10,
      OP_SUB    = 2'b11
   } op_e;

   // Upper opcode bit alone steers B inversion.
   function automatic logic op_inverts_b(input op_e op);
      return op[1];
   endfunction

   // Carry-in of one only when both bits are set.
   function automatic logic op_carry_in(input op_e op);
      return op[1] & op[0];
   endfunction

   function automatic logic op_is_logic(input op_e op);
      return op == OP_NAND;
   endfunction

endpackage

// File: rtl/nas_alu_fa.sv
module nas_alu_fa (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);

   logic prop;
   logic gen;

   always_comb begin
      prop = a_i ^ b_i;
      gen  = a_i & b_i;
      s_o  = prop ^ c_i;
      c_o  = gen | (prop & c_i);
      if (!$isunknown({a_i, b_i, c_i})) begin
         assert_fa_stage_R2: assert ({c_o, s_o} == (2'(a_i) + 2'(b_i) + 2'(c_i)))
            else $error("full-adder stage mismatch");
      end
   end

endmodule

// File: rtl/nas_alu_ripple.sv
module nas_alu_ripple #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             inv_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   localparam int EXT_W = WIDTH + 1;

   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] b_eff;

   assign carry[0] = cin_i;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      assign b_eff[i] = b_i[i] ^ inv_i;
      nas_alu_fa u_fa (
         .a_i (a_i[i]),
         .b_i (b_eff[i]),
         .c_i (carry[i]),
         .s_o (sum_o[i]),
         .c_o (carry[i+1])
      );
   end

   assign cout_o = carry[WIDTH];

   logic [EXT_W-1:0] ref_total;
   always_comb begin
      ref_total = {1'b0, a_i} + {1'b0, (inv_i ? ~b_i : b_i)} + EXT_W'(cin_i);
      if (!$isunknown({a_i, b_i, inv_i, cin_i, sum_o, cout_o})) begin
         assert_chain_total_R3: assert ({cout_o, sum_o} == ref_total)
            else $error("ripple chain total mismatch");
      end
   end

endmodule

// File: rtl/nas_alu_zero.sv
module nas_alu_zero #(
   parameter int WIDTH = 4,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] val_i,
   output logic             zero_o
);

   localparam int NGROUPS = (WIDTH + GROUP - 1) / GROUP;

   logic [NGROUPS-1:0] grp_clear;

   for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
      localparam int LO = g * GROUP;
      localparam int HI = ((LO + GROUP) > WIDTH) ? (WIDTH - 1) : (LO + GROUP - 1);
      assign grp_clear[g] = ~|val_i[HI:LO];
   end

   assign zero_o = &grp_clear;

   always_comb begin
      if (!$isunknown({val_i, zero_o})) begin
         assert_zero_tree_R6: assert (zero_o == (val_i == '0))
            else $error("zero tree mismatch");
      end
   end

endmodule

// File: rtl/nas_alu.sv
module nas_alu
   import nas_alu_pkg::*;
#(
   parameter int WIDTH      = 4,
   parameter int ZERO_GROUP = 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [OP_W-1:0]  op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o,
   output logic             zero_o
);

   localparam int EXT_W = WIDTH + 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("nas_alu: WIDTH must be at least 1");
   end
   if (ZERO_GROUP < 1) begin : g_bad_group
      $error("nas_alu: ZERO_GROUP must be at least 1");
   end

   op_e              op;
   logic             inv_b;
   logic             cin;
   logic [WIDTH-1:0] nand_v;
   logic [WIDTH-1:0] sum;
   logic             cout;

   assign op     = op_e'(op_i);
   assign inv_b  = op_inverts_b(op);
   assign cin    = op_carry_in(op);
   assign nand_v = ~(a_i & b_i);

   nas_alu_ripple #(.WIDTH(WIDTH)) u_chain (
      .a_i    (a_i),
      .b_i    (b_i),
      .inv_i  (inv_b),
      .cin_i  (cin),
      .sum_o  (sum),
      .cout_o (cout)
   );

   assign result_o = op_is_logic(op) ? nand_v : sum;
   assign carry_o  = cout;

   nas_alu_zero #(.WIDTH(WIDTH), .GROUP(ZERO_GROUP)) u_zero (
      .val_i  (result_o),
      .zero_o (zero_o)
   );

   // Per-opcode checks written as inverse identities.
   logic [EXT_W-1:0] add_full;
   always_comb begin
      add_full = {1'b0, a_i} + {1'b0, b_i};
      if (!$isunknown({a_i, b_i, op_i, result_o, carry_o, zero_o})) begin
         if (op_i == 2'b00) begin
            assert_nand_R1: assert (((result_o & a_i & b_i) == '0) && ((result_o | (a_i & b_i)) == '1))
               else $error("NAND result wrong");
            assert_nand_carry_R5: assert (carry_o == add_full[WIDTH])
               else $error("NAND carry wrong");
         end
         if (op_i == 2'b01) begin
            assert_add_R2: assert (WIDTH'(result_o - b_i) == a_i)
               else $error("add result wrong");
         end
         if (op_i == 2'b11) begin
            assert_sub_R3: assert (WIDTH'(result_o + b_i) == a_i)
               else $error("sub result wrong");
            assert_sub_carry_R3: assert (carry_o == (a_i >= b_i))
               else $error("sub carry wrong");
         end
         if (op_i == 2'b10) begin
            assert_addinv_R4: assert (WIDTH'(result_o + b_i + 1'b1) == a_i)
               else $error("inverted add result wrong");
            assert_addinv_carry_R4: assert (carry_o == (a_i > b_i))
               else $error("inverted add carry wrong");
         end
         assert_zero_flag_R6: assert (zero_o == (result_o == '0))
            else $error("zero flag wrong");
      end
   end

endmodule

// File: tb/nas_alu_tb.sv
module nas_alu_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] a, b;
   logic [1:0] op;
   logic [3:0] result;
   logic       carry, zero;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   nas_alu u_dut (
      .a_i      (a),
      .b_i      (b),
      .op_i     (op),
      .result_o (result),
      .carry_o  (carry),
      .zero_o   (zero)
   );

   typedef struct packed {
      logic [3:0] a;
      logic [3:0] b;
      logic [1:0] op;
      logic [3:0] res;
      logic       c;
      logic       z;
   } item_t;

   item_t sb[$];

   function automatic item_t model(input logic [3:0] xa, input logic [3:0] xb, input logic [1:0] xop);
      item_t it;
      int    full;
      int    ia = int'(xa);
      int    ib = int'(xb);
      it.a  = xa;
      it.b  = xb;
      it.op = xop;
      case (xop)
         2'b00: full = ia + ib;
         2'b01: full = ia + ib;
         2'b10: full = ia + (15 - ib);
         default: full = ia + (16 - ib);
      endcase
      it.c   = (full >= 16);
      it.res = (xop == 2'b00) ? ~(xa & xb) : 4'(full % 16);
      it.z   = (it.res == 4'd0);
      return it;
   endfunction

   function automatic string res_tag(input logic [1:0] xop);
      case (xop)
         2'b00: return "R1";
         2'b01: return "R2";
         2'b10: return "R4";
         default: return "R3";
      endcase
   endfunction

   function automatic string carry_tag(input logic [1:0] xop);
      case (xop)
         2'b00: return "R5";
         2'b01: return "R2";
         2'b10: return "R4";
         default: return "R3";
      endcase
   endfunction

   task automatic send(input logic [3:0] xa, input logic [3:0] xb, input logic [1:0] xop);
      @(posedge clk);
      #1;
      a  = xa;
      b  = xb;
      op = xop;
      sb.push_back(model(xa, xb, xop));
   endtask

   // Monitor: samples at the falling edge, away from the driving edge.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         n_checks++;
         if (result !== it.res) begin
            n_fail++;
            $display("FAIL %s result a=%h b=%h op=%b: got %h expected %h",
                     res_tag(it.op), it.a, it.b, it.op, result, it.res);
         end
         n_checks++;
         if (carry !== it.c) begin
            n_fail++;
            $display("FAIL %s carry a=%h b=%h op=%b: got %b expected %b",
                     carry_tag(it.op), it.a, it.b, it.op, carry, it.c);
         end
         n_checks++;
         if (zero !== it.z) begin
            n_fail++;
            $display("FAIL R6 zero a=%h b=%h op=%b: got %b expected %b",
                     it.a, it.b, it.op, zero, it.z);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      a  = 4'h0;
      b  = 4'h0;
      op = 2'b00;
      repeat (3) @(posedge clk);
      // Reset state: all-zero inputs under NAND give 1111, carry 0, zero 0 (R1, R5, R6).
      sb.push_back(model(4'h0, 4'h0, 2'b00));
      @(posedge clk);
      rst_n = 1'b1;

      // Directed corners.
      send(4'b0101, 4'b0011, 2'b01);  // R2: 1000, carry 0
      send(4'b0111, 4'b0010, 2'b11);  // R3: 0101, carry 1
      send(4'b1111, 4'b1111, 2'b00);  // R1, R6: 0000, zero 1
      send(4'b0000, 4'b0000, 2'b01);  // R2, R6: zero 1
      send(4'b1111, 4'b0001, 2'b01);  // R2: wrap to 0000 with carry 1
      send(4'b0000, 4'b0000, 2'b11);  // R3: 0 - 0 gives carry 1, zero 1
      send(4'b0011, 4'b0100, 2'b11);  // R3: borrow case, carry 0
      send(4'b0110, 4'b0110, 2'b10);  // R4: A = B gives 1111, carry 0
      send(4'b0111, 4'b0110, 2'b10);  // R4: A = B + 1 gives 0000, carry 1
      send(4'b1111, 4'b1111, 2'b00);  // R5: NAND carry follows A + B = 30

      // Exhaustive sweep over every opcode and operand pair.
      for (int o = 0; o < 4; o++)
         for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
               send(4'(i), 4'(j), 2'(o));

      while (sb.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule